// File: doc/BRIEF.md
# Rectangle Block-Transfer Engine

The engine moves or fills a rectangle of pixels in a linear frame buffer. A host sets it up through a single-cycle register write port. It gives the engine a base address and a row stride for each of the source and the destination, the rectangle extent, a scan direction, an opcode, a fill colour, a write mask and a pixel format. Writing the destination-position register starts the job. The engine then visits every pixel of the rectangle. For each pixel it reads the source and/or the destination through a synchronous pixel memory port when the operation needs them, combines them with a 4-bit boolean function, merges the result under the write mask and writes it back.

The scan can begin at any of the four corners. This lets the host copy between overlapping areas without corrupting data: it picks the direction that reads each source pixel before that pixel is overwritten, and it supplies the coordinates of the corner the scan starts from. In fill mode the source is replaced by the fill colour and is never read. Pixels are 8, 16 or 32 bits wide. A pixel travels in the low bits of the 32-bit memory data word.

Top module: `blit_engine`

## Requirements
- R1: After reset `busy`, `err` and `mem_req` are 0, the write mask is all ones, and every other setting is zero.
- R2: A register write to address 10 (destination position) while idle launches the job when width and height are both non-zero. `busy` is 1 from the next cycle until the cycle after the final pixel write, and `mem_req` equals `busy`.
- R3: Pixel (x, y) of a surface is at byte address base + y*stride + x*B. B is 1, 2 or 4 for format codes 0, 1 and 2 (register 11, bits 1:0); code 3 behaves as 4 bytes. Registers: 0/1 source base/stride, 2/3 destination base/stride, 4 extent (width 31:16, height 15:0), 9 and 10 source and destination position (x 31:16, y 15:0).
- R4: Register 5 bits 1:0 pick the scan direction. With bit 1 clear, x runs upward from the supplied x; with bit 1 set, it runs downward. With bit 0 clear, y runs upward from the supplied y; with bit 0 set, it runs downward. X is the inner loop, and source and destination move together.
- R5: Opcode bits 11:8 (register 6) hold the raster function. Bit k of the code is the result for source s and destination d, where k = 2*(1-s) + (1-d). So 0 is clear, 3 is copy, 5 leaves the destination, 6 is xor and 15 is set.
- R6: When opcode bit 16 is set, the fill colour (register 7) replaces the source for every pixel, and no source read is issued.
- R7: The write mask (register 8) takes its low byte replicated four times for format 0, its low half replicated twice for format 1, and the full word otherwise. The written value is (f & m) | (old & ~m), truncated to the pixel width, with the upper bits zero.
- R8: Each pixel takes up to three consecutive cycles: a source read only when the function depends on the source and fill mode is off, then a destination read only when the function depends on the destination or the mask is not all ones over the pixel width, then the write. Read data arrives one cycle after the request.
- R9: A launch with zero width or zero height leaves `busy` at 0 and makes no memory request.
- R10: Any register write while `busy` is 1 changes no setting and starts nothing, and it sets `err`, which stays 1 until reset.
- R11: A copy between overlapping areas, scanned away from the overlap, leaves the destination equal to the source as it was before the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Job in progress |
| err | output | 1 | Sticky flag for a write rejected while busy |
| mem_req | output | 1 | Pixel memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the pixel |
| mem_wdata | output | 32 | Pixel write data, in the low bits |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The hardest case to reach is the overlapping copy. In that case the data the engine reads depends on what it wrote earlier in the same job, so a wrong scan order or a wrong starting corner shows up only as corrupted pixels later in the scan. The stimulus places the source and destination in one surface, offset by two columns, by one row and by both. For each offset it supplies the far corner and the matching direction code. A second hard case is a register write that arrives in the middle of a job. The bench issues it a few cycles after launch and then relaunches with untouched settings, so the transaction stream shows whether the rejected write had any effect.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam logic [3:0] A_SRC_BASE   = 4'd0;
    localparam logic [3:0] A_SRC_STRIDE = 4'd1;
    localparam logic [3:0] A_DST_BASE   = 4'd2;
    localparam logic [3:0] A_DST_STRIDE = 4'd3;
    localparam logic [3:0] A_EXTENT     = 4'd4;
    localparam logic [3:0] A_SCAN       = 4'd5;
    localparam logic [3:0] A_OPCODE     = 4'd6;
    localparam logic [3:0] A_FILL       = 4'd7;
    localparam logic [3:0] A_WMASK      = 4'd8;
    localparam logic [3:0] A_SRC_POS    = 4'd9;
    localparam logic [3:0] A_DST_POS    = 4'd10;
    localparam logic [3:0] A_PIXFMT     = 4'd11;

    localparam int unsigned OPC_FN_LSB    = 8;
    localparam int unsigned OPC_SOLID_BIT = 16;

    typedef enum logic [1:0] {PH_IDLE, PH_RSRC, PH_RDST, PH_WR} phase_e;
    typedef enum logic [1:0] {RD_NONE, RD_SRC, RD_DST} rdsel_e;

    function automatic logic [31:0] spread_mask(input logic [1:0] fmt, input logic [31:0] m);
        case (fmt)
            2'd0:    return {4{m[7:0]}};
            2'd1:    return {2{m[15:0]}};
            default: return m;
        endcase
    endfunction

    function automatic logic [31:0] pix_width_mask(input logic [1:0] fmt);
        case (fmt)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [1:0] pix_shift(input logic [1:0] fmt);
        case (fmt)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic fn_uses_src(input logic [3:0] c);
        return (c[0] != c[2]) || (c[1] != c[3]);
    endfunction

    function automatic logic fn_uses_dst(input logic [3:0] c);
        return (c[0] != c[1]) || (c[2] != c[3]);
    endfunction

endpackage

// File: rtl/blit_scan.sv
module blit_scan #(
    parameter int unsigned COORD_W = 16
) (
    input  logic [COORD_W-1:0] start,
    input  logic [COORD_W-1:0] step_cnt,
    input  logic               reverse,
    output logic [COORD_W-1:0] pos
);
    assign pos = reverse ? (start - step_cnt) : (start + step_cnt);
endmodule

// File: rtl/blit_addr.sv
module blit_addr #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned COORD_W = 16
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [COORD_W-1:0] stride,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [1:0]         shift,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] row_off;
    logic [ADDR_W-1:0] col_off;

    assign row_off = ADDR_W'(y) * ADDR_W'(stride);
    assign col_off = ADDR_W'(x) << shift;
    assign addr    = base + row_off + col_off;
endmodule

// File: rtl/blit_rop.sv
module blit_rop
    import blit_pkg::*;
(
    input  logic [3:0]  fn_code,
    input  logic [1:0]  fmt,
    input  logic [31:0] mask_raw,
    input  logic [31:0] src,
    input  logic [31:0] dst,
    output logic [31:0] pix
);
    logic [31:0] raw;
    logic [31:0] m;

    for (genvar i = 0; i < 32; i++) begin : g_bit
        assign raw[i] = fn_code[{~src[i], ~dst[i]}];
    end

    assign m   = spread_mask(fmt, mask_raw);
    assign pix = ((raw & m) | (dst & ~m)) & pix_width_mask(fmt);
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned COORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              busy,
    output logic              err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    localparam int unsigned XHI = 16 + COORD_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0]  sbase;
        logic [ADDR_W-1:0]  dbase;
        logic [COORD_W-1:0] sstride;
        logic [COORD_W-1:0] dstride;
        logic [COORD_W-1:0] w;
        logic [COORD_W-1:0] h;
        logic [COORD_W-1:0] sx;
        logic [COORD_W-1:0] sy;
        logic [COORD_W-1:0] dx;
        logic [COORD_W-1:0] dy;
        logic [COORD_W-1:0] xc;
        logic [COORD_W-1:0] yc;
        logic [1:0]         dir;
        logic [1:0]         fmt;
        logic [3:0]         fn;
        logic               solid;
        logic [31:0]        fore;
        logic [31:0]        mask;
        logic [31:0]        sdat;
        logic [31:0]        ddat;
        phase_e             ph;
        rdsel_e             rd;
        logic               err;
    } st_t;

    st_t q, d;

    logic               need_src, need_dst, masking;
    phase_e             first_ph;
    logic [31:0]        src_now, dst_now, src_opnd, pix;
    logic [COORD_W-1:0] cur_sx, cur_sy, cur_dx, cur_dy;
    logic [ADDR_W-1:0]  saddr, daddr;
    logic [COORD_W-1:0] cfg_w, cfg_h;
    logic [1:0]         cfg_fmt;

    assign masking  = (spread_mask(q.fmt, q.mask) | ~pix_width_mask(q.fmt)) != 32'hFFFF_FFFF;
    assign need_src = !q.solid && fn_uses_src(q.fn);
    assign need_dst = fn_uses_dst(q.fn) || masking;
    assign first_ph = need_src ? PH_RSRC : (need_dst ? PH_RDST : PH_WR);

    assign src_now  = (q.rd == RD_SRC) ? mem_rdata : q.sdat;
    assign dst_now  = (q.rd == RD_DST) ? mem_rdata : q.ddat;
    assign src_opnd = q.solid ? q.fore : src_now;

    blit_scan #(.COORD_W(COORD_W)) u_scan_sx (.start(q.sx), .step_cnt(q.xc), .reverse(q.dir[1]), .pos(cur_sx));
    blit_scan #(.COORD_W(COORD_W)) u_scan_sy (.start(q.sy), .step_cnt(q.yc), .reverse(q.dir[0]), .pos(cur_sy));
    blit_scan #(.COORD_W(COORD_W)) u_scan_dx (.start(q.dx), .step_cnt(q.xc), .reverse(q.dir[1]), .pos(cur_dx));
    blit_scan #(.COORD_W(COORD_W)) u_scan_dy (.start(q.dy), .step_cnt(q.yc), .reverse(q.dir[0]), .pos(cur_dy));

    blit_addr #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_addr_src (
        .base(q.sbase), .stride(q.sstride), .x(cur_sx), .y(cur_sy),
        .shift(pix_shift(q.fmt)), .addr(saddr));
    blit_addr #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_addr_dst (
        .base(q.dbase), .stride(q.dstride), .x(cur_dx), .y(cur_dy),
        .shift(pix_shift(q.fmt)), .addr(daddr));

    blit_rop u_rop (
        .fn_code(q.fn), .fmt(q.fmt), .mask_raw(q.mask),
        .src(src_opnd), .dst(dst_now), .pix(pix));

    always_comb begin
        d    = q;
        d.rd = RD_NONE;
        if (q.rd == RD_SRC) d.sdat = mem_rdata;
        if (q.rd == RD_DST) d.ddat = mem_rdata;

        if (reg_we) begin
            if (q.ph != PH_IDLE) begin
                d.err = 1'b1;
            end else begin
                case (reg_addr)
                    A_SRC_BASE:   d.sbase   = ADDR_W'(reg_wdata);
                    A_SRC_STRIDE: d.sstride = reg_wdata[COORD_W-1:0];
                    A_DST_BASE:   d.dbase   = ADDR_W'(reg_wdata);
                    A_DST_STRIDE: d.dstride = reg_wdata[COORD_W-1:0];
                    A_EXTENT: begin
                        d.w = reg_wdata[XHI:16];
                        d.h = reg_wdata[COORD_W-1:0];
                    end
                    A_SCAN:   d.dir   = reg_wdata[1:0];
                    A_OPCODE: begin
                        d.fn    = reg_wdata[OPC_FN_LSB +: 4];
                        d.solid = reg_wdata[OPC_SOLID_BIT];
                    end
                    A_FILL:   d.fore = reg_wdata;
                    A_WMASK:  d.mask = reg_wdata;
                    A_SRC_POS: begin
                        d.sx = reg_wdata[XHI:16];
                        d.sy = reg_wdata[COORD_W-1:0];
                    end
                    A_DST_POS: begin
                        d.dx = reg_wdata[XHI:16];
                        d.dy = reg_wdata[COORD_W-1:0];
                        if (q.w != '0 && q.h != '0) begin
                            d.xc = '0;
                            d.yc = '0;
                            d.ph = first_ph;
                        end
                    end
                    A_PIXFMT: d.fmt = reg_wdata[1:0];
                    default: ;
                endcase
            end
        end

        case (q.ph)
            PH_RSRC: begin
                d.rd = RD_SRC;
                d.ph = need_dst ? PH_RDST : PH_WR;
            end
            PH_RDST: begin
                d.rd = RD_DST;
                d.ph = PH_WR;
            end
            PH_WR: begin
                if (q.xc == q.w - 1'b1) begin
                    if (q.yc == q.h - 1'b1) begin
                        d.ph = PH_IDLE;
                    end else begin
                        d.xc = '0;
                        d.yc = q.yc + 1'b1;
                        d.ph = first_ph;
                    end
                end else begin
                    d.xc = q.xc + 1'b1;
                    d.ph = first_ph;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= 32'hFFFF_FFFF;
            q.ph   <= PH_IDLE;
            q.rd   <= RD_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.ph != PH_IDLE);
    assign err       = q.err;
    assign mem_req   = busy;
    assign mem_we    = (q.ph == PH_WR);
    assign mem_addr  = (q.ph == PH_RSRC) ? saddr : daddr;
    assign mem_wdata = mem_we ? pix : 32'h0;

    assign cfg_w   = q.w;
    assign cfg_h   = q.h;
    assign cfg_fmt = q.fmt;
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk
    import blit_pkg::*;
#(
    parameter int unsigned COORD_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [3:0]         reg_addr,
    input logic               busy,
    input logic               err,
    input logic               mem_req,
    input logic               mem_we,
    input logic [31:0]        mem_wdata,
    input logic [COORD_W-1:0] cfg_w,
    input logic [COORD_W-1:0] cfg_h,
    input logic [1:0]         cfg_fmt
);
    logic launch;
    assign launch = reg_we && (reg_addr == A_DST_POS) && !busy;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_w != '0 && cfg_h != '0) |=> busy);

    assert_zero_extent_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && (cfg_w == '0 || cfg_h == '0)) |=> !busy);

    assert_reject_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && busy) |=> err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_byte_pixel_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cfg_fmt == 2'd0) |-> (mem_wdata[31:8] == 24'h0));

    assert_write_inside_job_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

bind blit_engine blit_engine_chk #(.COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .busy(busy), .err(err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .cfg_w(cfg_w), .cfg_h(cfg_h), .cfg_fmt(cfg_fmt));

// File: tb/test_blit_engine.sv
module test_blit_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        busy, err, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    blit_engine i_blit_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .err(err), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata));

    // ---------------- pixel memory ----------------
    logic [31:0] mem [int unsigned];

    function automatic logic [31:0] init_val(input int unsigned a);
        return (a * 32'h0100_0193) ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] rdm(input int unsigned a);
        return mem.exists(a) ? mem[a] : init_val(a);
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata <= rdm(mem_addr);
        end
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit          we;
        int unsigned addr;
        logic [31:0] data;
        string       req;
    } txn_t;

    txn_t pend[$];
    txn_t exp_q[$];

    int unsigned c_sbase, c_dbase, c_sstr, c_dstr;
    int unsigned c_w, c_h, c_sx, c_sy, c_dx, c_dy;
    logic [1:0]  c_dir, c_fmt;
    logic [3:0]  c_fn;
    bit          c_solid;
    logic [31:0] c_fore, c_mask;

    function automatic logic [31:0] ref_fn(input logic [3:0] c, input logic [31:0] s, input logic [31:0] dv);
        case (c)
            4'd0:  return 32'h0;
            4'd1:  return s & dv;
            4'd2:  return s & ~dv;
            4'd3:  return s;
            4'd4:  return ~s & dv;
            4'd5:  return dv;
            4'd6:  return s ^ dv;
            4'd7:  return s | dv;
            4'd8:  return ~(s | dv);
            4'd9:  return ~(s ^ dv);
            4'd10: return ~dv;
            4'd11: return s | ~dv;
            4'd12: return ~s;
            4'd13: return ~s | dv;
            4'd14: return ~(s & dv);
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int unsigned bpp_bytes(input logic [1:0] f);
        return (f == 2'd0) ? 1 : (f == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] wmask(input logic [1:0] f);
        return (f == 2'd0) ? 32'hFF : (f == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] emask(input logic [1:0] f, input logic [31:0] m);
        if (f == 2'd0) return {m[7:0], m[7:0], m[7:0], m[7:0]};
        if (f == 2'd1) return {m[15:0], m[15:0]};
        return m;
    endfunction

    task automatic build_model(input string tag);
        logic [31:0] shadow [int unsigned];
        int unsigned bb;
        logic [31:0] wm, me;
        bit uses_s, uses_d, need_s, need_d;
        shadow = mem;
        bb = bpp_bytes(c_fmt);
        wm = wmask(c_fmt);
        me = emask(c_fmt, c_mask);
        uses_s = (ref_fn(c_fn, '1, 0) != ref_fn(c_fn, 0, 0)) || (ref_fn(c_fn, '1, '1) != ref_fn(c_fn, 0, '1));
        uses_d = (ref_fn(c_fn, 0, '1) != ref_fn(c_fn, 0, 0)) || (ref_fn(c_fn, '1, '1) != ref_fn(c_fn, '1, 0));
        need_s = !c_solid && uses_s;
        need_d = uses_d || ((me & wm) != wm);
        pend.delete();
        for (int yi = 0; yi < int'(c_h); yi++) begin
            for (int xi = 0; xi < int'(c_w); xi++) begin
                int unsigned xs, ys, xd, yd, sa, da;
                logic [31:0] s, dv, res;
                xs = c_dir[1] ? c_sx - xi : c_sx + xi;
                xd = c_dir[1] ? c_dx - xi : c_dx + xi;
                ys = c_dir[0] ? c_sy - yi : c_sy + yi;
                yd = c_dir[0] ? c_dy - yi : c_dy + yi;
                sa = c_sbase + ys * c_sstr + xs * bb;
                da = c_dbase + yd * c_dstr + xd * bb;
                s  = c_solid ? c_fore : (shadow.exists(sa) ? shadow[sa] : init_val(sa));
                dv = shadow.exists(da) ? shadow[da] : init_val(da);
                if (need_s) pend.push_back('{0, sa, 32'h0, {tag, " R8 src read"}});
                if (need_d) pend.push_back('{0, da, 32'h0, {tag, " R8 dst read"}});
                res = ((ref_fn(c_fn, s, dv) & me) | (dv & ~me)) & wm;
                pend.push_back('{1, da, res, {tag, " R5/R7 write"}});
                shadow[da] = res;
            end
        end
    endtask

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            n_checks++;
            if (busy !== (exp_q.size() != 0)) begin
                n_fail++;
                $display("FAIL R2 busy: actual %0b expected %0b", busy, exp_q.size() != 0);
            end
            if (mem_req) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9/R8 unexpected request: actual addr %h expected none", mem_addr);
                end else begin
                    txn_t e;
                    e = exp_q.pop_front();
                    if (mem_we !== e.we || mem_addr !== e.addr || (e.we && mem_wdata !== e.data)) begin
                        n_fail++;
                        $display("FAIL %s R3/R4: actual we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                                 e.req, mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
                    end
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic program_all();
        wreg(4'd0, c_sbase);
        wreg(4'd1, c_sstr);
        wreg(4'd2, c_dbase);
        wreg(4'd3, c_dstr);
        wreg(4'd4, (c_w << 16) | c_h);
        wreg(4'd5, {30'h0, c_dir});
        wreg(4'd6, (32'(c_solid) << 16) | (32'(c_fn) << 8));
        wreg(4'd7, c_fore);
        wreg(4'd8, c_mask);
        wreg(4'd11, {30'h0, c_fmt});
        wreg(4'd9, (c_sx << 16) | c_sy);
    endtask

    task automatic launch();
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd10; reg_wdata = (c_dx << 16) | c_dy;
        @(posedge clk);
        #1 exp_q = pend;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int cnt = 0;
        while ((busy || exp_q.size() != 0) && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt < 5000, {req, " job finished"}, 32'(cnt), 32'd5000);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_job(input string tag);
        program_all();
        build_model(tag);
        launch();
        wait_idle(tag);
    endtask

    // compare destination with pre-job source snapshot (copy function)
    task automatic check_ideal(input logic [31:0] snap [int unsigned], input string req);
        int unsigned bb, sl, st, dl, dt;
        bb = bpp_bytes(c_fmt);
        sl = c_dir[1] ? c_sx - (c_w - 1) : c_sx;
        dl = c_dir[1] ? c_dx - (c_w - 1) : c_dx;
        st = c_dir[0] ? c_sy - (c_h - 1) : c_sy;
        dt = c_dir[0] ? c_dy - (c_h - 1) : c_dy;
        for (int yi = 0; yi < int'(c_h); yi++) begin
            for (int xi = 0; xi < int'(c_w); xi++) begin
                int unsigned sa, da;
                logic [31:0] ev;
                sa = c_sbase + (st + yi) * c_sstr + (sl + xi) * bb;
                da = c_dbase + (dt + yi) * c_dstr + (dl + xi) * bb;
                ev = (snap.exists(sa) ? snap[sa] : init_val(sa)) & wmask(c_fmt);
                check(rdm(da) === ev, req, rdm(da), ev);
            end
        end
    endtask

    task automatic set_default();
        c_sbase = 32'h1000; c_dbase = 32'h8000; c_sstr = 256; c_dstr = 256;
        c_w = 4; c_h = 3; c_sx = 2; c_sy = 1; c_dx = 5; c_dy = 2;
        c_dir = 2'd0; c_fmt = 2'd2; c_fn = 4'd3; c_solid = 0;
        c_fore = 32'h0; c_mask = 32'hFFFF_FFFF;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] snap [int unsigned];
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && err === 1'b0 && mem_req === 1'b0, "R1 reset outputs",
              {29'h0, busy, err, mem_req}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy === 1'b0 && mem_req === 1'b0, "R1 idle after reset", {30'h0, busy, mem_req}, 32'h0);

        // R2/R3/R8: plain 32-bit copy, only source reads
        set_default();
        run_job("R2 R3 copy32");

        // R7: 8-bit xor with partial mask, replicated
        set_default();
        c_fmt = 2'd0; c_fn = 4'd6; c_mask = 32'h0000_000F; c_dstr = 100; c_sstr = 64;
        run_job("R7 xor8 mask");

        // R6: 16-bit solid fill, no source reads
        set_default();
        c_fmt = 2'd1; c_solid = 1; c_fore = 32'hDEAD_1234; c_w = 5; c_h = 2;
        run_job("R6 fill16");

        // R5: solid clear with full mask, write only
        set_default();
        c_solid = 1; c_fn = 4'd0;
        run_job("R5 clear");

        // R5: every function code on 8-bit pixels with a mask
        for (int f = 0; f < 16; f++) begin
            set_default();
            c_fmt = 2'd0; c_fn = 4'(f); c_w = 2; c_h = 2; c_mask = 32'h0000_00F3;
            c_sbase = 32'h2000 + 32'(f) * 16;
            run_job($sformatf("R5 fn%0d", f));
        end

        // R7: 16-bit mask, set function
        set_default();
        c_fmt = 2'd1; c_fn = 4'd15; c_mask = 32'h0000_0FF0;
        run_job("R7 set16");

        // R11/R4: overlap, shift right by two columns, right-to-left
        set_default();
        c_sbase = 32'h4000; c_dbase = 32'h4000; c_sstr = 64; c_dstr = 64;
        c_w = 4; c_h = 2; c_dir = 2'd2; c_sx = 4; c_sy = 2; c_dx = 6; c_dy = 2;
        snap = mem;
        run_job("R4 RL overlap");
        check_ideal(snap, "R11 RL overlap");

        // R11/R4: overlap, shift down one row, bottom-to-top
        set_default();
        c_sbase = 32'h5000; c_dbase = 32'h5000; c_sstr = 64; c_dstr = 64;
        c_w = 3; c_h = 3; c_dir = 2'd1; c_sx = 1; c_sy = 3; c_dx = 1; c_dy = 4;
        snap = mem;
        run_job("R4 BT overlap");
        check_ideal(snap, "R11 BT overlap");

        // R11/R4: overlap in both axes
        set_default();
        c_sbase = 32'h6000; c_dbase = 32'h6000; c_sstr = 64; c_dstr = 64; c_fmt = 2'd1;
        c_w = 3; c_h = 3; c_dir = 2'd3; c_sx = 3; c_sy = 3; c_dx = 4; c_dy = 4;
        snap = mem;
        run_job("R4 RLBT overlap");
        check_ideal(snap, "R11 RLBT overlap");

        // R9: zero width, then zero height
        set_default();
        c_w = 0;
        run_job("R9 zero width");
        check(busy === 1'b0, "R9 zero width idle", {31'h0, busy}, 32'h0);
        set_default();
        c_h = 0;
        run_job("R9 zero height");
        check(busy === 1'b0, "R9 zero height idle", {31'h0, busy}, 32'h0);
        check(err === 1'b0, "R10 err clear before busy write", {31'h0, err}, 32'h0);

        // R10: writes during a job are rejected and set err
        set_default();
        c_w = 6; c_h = 3;
        program_all();
        build_model("R10 job");
        launch();
        repeat (3) @(negedge clk);
        wreg(4'd6, 32'h0000_0F00);
        wreg(4'd10, 32'h0001_0001);
        wreg(4'd4, 32'h0001_0001);
        wait_idle("R10 job");
        check(err === 1'b1, "R10 err set", {31'h0, err}, 32'h1);
        build_model("R10 relaunch unchanged");
        launch();
        wait_idle("R10 relaunch");
        check(err === 1'b1, "R10 err sticky", {31'h0, err}, 32'h1);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule